// File: doc/BRIEF.md
# DSI Video Timing Converter

This block turns a display mode, described in pixel clocks and lines, into the horizontal and vertical timing values that a DSI host controller needs in video mode. The horizontal line period, sync-active time and back-porch time are rescaled into lane-byte-clock cycles. The scaling uses the pixel clock in kHz and the bit rate of one lane. The four vertical values come out as line counts.

Software or a mode-setting engine places the mode on the inputs and pulses `start_i` while the block is idle. The block copies the inputs into its own registers. It then runs each of the three horizontal components in turn through one multiply and two divisions on a shared one-bit-per-cycle restoring divider. The first division is a floor division by 8000 and the second is a ceiling division by the pixel clock. When all seven results are ready, the block updates its outputs and raises `done_o` for one cycle. The outputs then hold their values until the next job completes.

The controller has six states:
- IDLE waits for start.
- SCALE launches the floor division of component × lane rate by 8000.
- WAIT_A waits for that division, then launches the rounded-up division by the pixel clock.
- WAIT_B waits for the second quotient and stores it.
- NEXT moves to the following component, or goes to DONE after the third.
- DONE pulses done and returns to IDLE.

When the pixel clock is zero, SCALE stores a zero and goes straight to NEXT.

Top module: `dsi_vtiming_conv`

## Requirements
- R1: `start_i` is taken only in IDLE. `busy_o` is 1 from the cycle after an accepted start until the result cycle. A `start_i` or an input change while busy has no effect on the job in flight and does not queue a second job.
- R2: `done_o` is high for exactly one cycle. In that cycle `busy_o` is 0 and all seven results and `err_o` are valid.
- R3: The line time is ceil(floor((h_active + h_blank) × lane_bps / 8000) / pclk_khz), where the sum is formed one bit wider than the inputs.
- R4: The sync-active time uses the same formula applied to the horizontal sync width.
- R5: The horizontal back porch is h_blank − h_sync_off − h_sync_w, converted with the same formula.
- R6: The vertical active and vertical sync outputs equal their inputs. The vertical front porch equals the vertical sync offset.
- R7: The vertical back porch is v_blank − v_sync_off − v_sync_w, in lines.
- R8: If a blanking value is smaller than its sync offset plus sync width, `err_o` is 1 and that back porch is 0. The horizontal and vertical checks are made separately.
- R9: If pclk_khz is 0, `err_o` is 1 and all three horizontal outputs are 0.
- R10: All outputs change only on the edge that raises `done_o`. They hold through later cycles even when the inputs change.
- R11: After reset, `busy_o`, `done_o`, `err_o` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when idle |
| h_active_i | input | H_W | Horizontal active pixels |
| h_blank_i | input | H_W | Horizontal blanking pixels |
| h_sync_off_i | input | H_W | Horizontal sync offset (front porch) |
| h_sync_w_i | input | H_W | Horizontal sync width |
| v_active_i | input | H_W | Vertical active lines |
| v_blank_i | input | H_W | Vertical blanking lines |
| v_sync_off_i | input | H_W | Vertical sync offset |
| v_sync_w_i | input | H_W | Vertical sync width |
| pclk_khz_i | input | CLK_W | Pixel clock in kHz |
| lane_bps_i | input | BPS_W | Bit rate per lane |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Blanking underflow or zero pixel clock |
| hline_lbcc_o | output | H_W+1+BPS_W | Line period in lane-byte clocks |
| hsa_lbcc_o | output | H_W+1+BPS_W | Sync-active time in lane-byte clocks |
| hbp_lbcc_o | output | H_W+1+BPS_W | Back-porch time in lane-byte clocks |
| v_active_o | output | H_W | Vertical active lines |
| v_sync_o | output | H_W | Vertical sync lines |
| v_front_o | output | H_W | Vertical front-porch lines |
| v_back_o | output | H_W | Vertical back-porch lines |

## Verification
Two functions can fall in the same cycle.

The first pair is a start request and the completion of a job. `start_i` is pulsed, with different mode inputs, while the divider is mid-run. The bench then checks three things: the results match the first mode, `busy_o` stays low after the single `done_o`, and the held outputs do not change.

The second pair is the horizontal and vertical underflow checks. The sweep includes modes in which only one of the two blankings, or both, are too small. This shows that each back porch is forced to zero on its own and that `err_o` combines the two.

// File: rtl/dsi_tc_pkg.sv
`timescale 1ns/1ps
package dsi_tc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCALE,
        S_WAIT_A,
        S_WAIT_B,
        S_NEXT,
        S_DONE
    } conv_state_t;

    typedef enum logic {
        D_IDLE,
        D_RUN
    } div_state_t;

    localparam int N_HCOMP = 3;

endpackage

// File: rtl/dsi_tc_div.sv
`timescale 1ns/1ps
module dsi_tc_div
    import dsi_tc_pkg::*;
#(
    parameter int W = 49
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         ceil_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);

    localparam int CNT_W = $clog2(W + 1);
    localparam int W2    = 2 * W;

    div_state_t     st_q;
    logic [W-1:0]   rem_q, quo_q, den_q, num_q, quot_q;
    logic           ceil_q, done_q;
    logic [CNT_W-1:0] cnt_q;

    logic [W:0]     rem_sh, rem_df;
    logic           ge;
    logic [W-1:0]   rem_nx, quo_nx, fin_q;

    // one restoring step: shift in the next dividend bit, subtract if it fits
    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        ge     = rem_sh >= {1'b0, den_q};
        rem_df = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
        rem_nx = rem_df[W-1:0];
        quo_nx = {quo_q[W-2:0], ge};
        fin_q  = quo_nx + {{(W-1){1'b0}}, (ceil_q && (rem_nx != '0))};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= D_IDLE;
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            quot_q <= '0;
            ceil_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                D_IDLE: begin
                    if (start_i) begin
                        rem_q  <= '0;
                        quo_q  <= dividend_i;
                        num_q  <= dividend_i;
                        den_q  <= divisor_i;
                        ceil_q <= ceil_i;
                        cnt_q  <= CNT_W'(W);
                        st_q   <= D_RUN;
                    end
                end
                D_RUN: begin
                    rem_q <= rem_nx;
                    quo_q <= quo_nx;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        quot_q <= fin_q;
                        done_q <= 1'b1;
                        st_q   <= D_IDLE;
                    end
                end
                default: st_q <= D_IDLE;
            endcase
        end
    end

    assign done_o = done_q;
    assign quot_o = quot_q;

    // R3: floor quotient q satisfies q*d <= n < (q+1)*d
    a_r3_floor_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !ceil_q && den_q != '0) |->
        (({{W{1'b0}}, quot_q} * {{W{1'b0}}, den_q}) <= W2'(num_q)) &&
        (({{W{1'b0}}, quot_q} * {{W{1'b0}}, den_q} + W2'(den_q)) > W2'(num_q)));

    // R3: rounded-up quotient q satisfies n <= q*d < n + d
    a_r3_ceil_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && ceil_q && den_q != '0) |->
        (({{W{1'b0}}, quot_q} * {{W{1'b0}}, den_q}) >= W2'(num_q)) &&
        (({{W{1'b0}}, quot_q} * {{W{1'b0}}, den_q}) < (W2'(num_q) + W2'(den_q))));

    a_r2_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/dsi_vtiming_conv.sv
`timescale 1ns/1ps
module dsi_vtiming_conv
    import dsi_tc_pkg::*;
#(
    parameter int H_W      = 16,
    parameter int BPS_W    = 32,
    parameter int CLK_W    = 20,
    parameter int BYTE_DIV = 8000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [H_W-1:0]           h_active_i,
    input  logic [H_W-1:0]           h_blank_i,
    input  logic [H_W-1:0]           h_sync_off_i,
    input  logic [H_W-1:0]           h_sync_w_i,
    input  logic [H_W-1:0]           v_active_i,
    input  logic [H_W-1:0]           v_blank_i,
    input  logic [H_W-1:0]           v_sync_off_i,
    input  logic [H_W-1:0]           v_sync_w_i,
    input  logic [CLK_W-1:0]         pclk_khz_i,
    input  logic [BPS_W-1:0]         lane_bps_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     err_o,
    output logic [H_W+BPS_W:0]       hline_lbcc_o,
    output logic [H_W+BPS_W:0]       hsa_lbcc_o,
    output logic [H_W+BPS_W:0]       hbp_lbcc_o,
    output logic [H_W-1:0]           v_active_o,
    output logic [H_W-1:0]           v_sync_o,
    output logic [H_W-1:0]           v_front_o,
    output logic [H_W-1:0]           v_back_o
);

    localparam int C_W = H_W + 1;
    localparam int D_W = C_W + BPS_W;
    localparam logic [D_W-1:0] BYTE_DIV_W = D_W'(BYTE_DIV);

    conv_state_t state_q, state_d;

    // captured job
    logic [C_W-1:0]   comp_q [N_HCOMP];
    logic [CLK_W-1:0] pclk_q;
    logic [BPS_W-1:0] bps_q;
    logic [H_W-1:0]   vact_q, vsync_q, vfront_q, vback_q;
    logic             err_q;
    logic [D_W-1:0]   res_q [N_HCOMP];
    logic [1:0]       idx_q;

    // divider control
    logic             div_start, div_ceil, div_done;
    logic [D_W-1:0]   div_num, div_den, div_quot;

    logic [C_W-1:0]   comp_sel;
    logic [D_W-1:0]   prod;
    logic             pclk_zero;
    logic             store_en;

    // input-side checks for a new job
    logic [C_W-1:0]   h_sum, v_sum;
    logic             h_under, v_under;
    logic [C_W-1:0]   hbp_raw, vbp_raw;

    always_comb begin
        h_sum   = {1'b0, h_sync_off_i} + {1'b0, h_sync_w_i};
        v_sum   = {1'b0, v_sync_off_i} + {1'b0, v_sync_w_i};
        h_under = {1'b0, h_blank_i} < h_sum;
        v_under = {1'b0, v_blank_i} < v_sum;
        hbp_raw = {1'b0, h_blank_i} - h_sum;
        vbp_raw = {1'b0, v_blank_i} - v_sum;
    end

    always_comb begin
        comp_sel  = comp_q[idx_q];
        prod      = {{BPS_W{1'b0}}, comp_sel} * {{C_W{1'b0}}, bps_q};
        pclk_zero = (pclk_q == '0);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and divider requests
    always_comb begin
        state_d   = state_q;
        div_start = 1'b0;
        div_ceil  = 1'b0;
        div_num   = prod;
        div_den   = BYTE_DIV_W;
        store_en  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = S_SCALE;
            end
            S_SCALE: begin
                if (pclk_zero) begin
                    store_en = 1'b1;
                    state_d  = S_NEXT;
                end else begin
                    div_start = 1'b1;
                    state_d   = S_WAIT_A;
                end
            end
            S_WAIT_A: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_ceil  = 1'b1;
                    div_num   = div_quot;
                    div_den   = {{(D_W-CLK_W){1'b0}}, pclk_q};
                    state_d   = S_WAIT_B;
                end
            end
            S_WAIT_B: begin
                if (div_done) begin
                    store_en = 1'b1;
                    state_d  = S_NEXT;
                end
            end
            S_NEXT: begin
                if (idx_q == 2'(N_HCOMP - 1)) state_d = S_DONE;
                else                          state_d = S_SCALE;
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    dsi_tc_div #(.W(D_W)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .ceil_i     (div_ceil),
        .dividend_i (div_num),
        .divisor_i  (div_den),
        .done_o     (div_done),
        .quot_o     (div_quot)
    );

    // job capture and per-component results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_HCOMP; i++) begin
                comp_q[i] <= '0;
                res_q[i]  <= '0;
            end
            pclk_q   <= '0;
            bps_q    <= '0;
            vact_q   <= '0;
            vsync_q  <= '0;
            vfront_q <= '0;
            vback_q  <= '0;
            err_q    <= 1'b0;
            idx_q    <= '0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                comp_q[0] <= {1'b0, h_active_i} + {1'b0, h_blank_i};
                comp_q[1] <= {1'b0, h_sync_w_i};
                comp_q[2] <= h_under ? '0 : hbp_raw;
                pclk_q    <= pclk_khz_i;
                bps_q     <= lane_bps_i;
                vact_q    <= v_active_i;
                vsync_q   <= v_sync_w_i;
                vfront_q  <= v_sync_off_i;
                vback_q   <= v_under ? '0 : vbp_raw[H_W-1:0];
                err_q     <= h_under || v_under || (pclk_khz_i == '0);
                idx_q     <= '0;
            end
            if (store_en) res_q[idx_q] <= pclk_zero ? '0 : div_quot;
            if (state_q == S_NEXT && state_d == S_SCALE) idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hline_lbcc_o <= '0;
            hsa_lbcc_o   <= '0;
            hbp_lbcc_o   <= '0;
            v_active_o   <= '0;
            v_sync_o     <= '0;
            v_front_o    <= '0;
            v_back_o     <= '0;
            err_o        <= 1'b0;
        end else if (state_q == S_NEXT && state_d == S_DONE) begin
            hline_lbcc_o <= res_q[0];
            hsa_lbcc_o   <= res_q[1];
            hbp_lbcc_o   <= res_q[2];
            v_active_o   <= vact_q;
            v_sync_o     <= vsync_q;
            v_front_o    <= vfront_q;
            v_back_o     <= vback_q;
            err_o        <= err_q;
        end
    end

    assign busy_o = (state_q != S_IDLE) && (state_q != S_DONE);
    assign done_o = (state_q == S_DONE);

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o);

    a_r1_busy_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r2_busy_falls_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r10_hold_between_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hline_lbcc_o) && $stable(hsa_lbcc_o) && $stable(hbp_lbcc_o)
                     && $stable(v_back_o) && $stable(err_o)));

    a_r9_zero_pclk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (pclk_q != '0));

endmodule

// File: tb/dsi_vtiming_conv_tb.sv
`timescale 1ns/1ps
module dsi_vtiming_conv_tb_top;

    localparam int H_W = 16, BPS_W = 32, CLK_W = 20;
    localparam int D_W = H_W + 1 + BPS_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [H_W-1:0] ha, hbl, hso, hsw, va, vbl, vso, vsw;
    logic [CLK_W-1:0] pclk;
    logic [BPS_W-1:0] bps;
    logic busy_o, done_o, err_o;
    logic [D_W-1:0] hline_o, hsa_o, hbp_o;
    logic [H_W-1:0] vact_o, vsync_o, vfront_o, vback_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    dsi_vtiming_conv dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .h_active_i(ha), .h_blank_i(hbl), .h_sync_off_i(hso), .h_sync_w_i(hsw),
        .v_active_i(va), .v_blank_i(vbl), .v_sync_off_i(vso), .v_sync_w_i(vsw),
        .pclk_khz_i(pclk), .lane_bps_i(bps),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .hline_lbcc_o(hline_o), .hsa_lbcc_o(hsa_o), .hbp_lbcc_o(hbp_o),
        .v_active_o(vact_o), .v_sync_o(vsync_o), .v_front_o(vfront_o), .v_back_o(vback_o)
    );

    task automatic chk(string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint unsigned ref_lbcc(longint unsigned comp,
                                                 longint unsigned rate,
                                                 longint unsigned pk);
        longint unsigned t;
        if (pk == 0) return 0;
        t = (comp * rate) / 64'd8000;
        return (t + pk - 1) / pk;
    endfunction

    // expected values of the current mode
    longint unsigned e_line, e_sa, e_bp, e_vbp;
    bit e_err;

    task automatic compute_exp();
        longint unsigned hs, vs;
        hs = longint'(hso) + longint'(hsw);
        vs = longint'(vso) + longint'(vsw);
        e_line = ref_lbcc(longint'(ha) + longint'(hbl), bps, pclk);
        e_sa   = ref_lbcc(hsw, bps, pclk);
        e_bp   = (hbl < hs) ? 0 : ref_lbcc(longint'(hbl) - hs, bps, pclk);
        e_vbp  = (vbl < vs) ? 0 : longint'(vbl) - vs;
        e_err  = (hbl < hs) || (vbl < vs) || (pclk == 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o) begin
            @(negedge clk);
            n++;
            if (n > 2000) begin
                checks++; fails++;
                $display("FAIL R2 actual=no_done expected=done");
                finish_run();
            end
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 busy after start", busy_o, 1);
    endtask

    task automatic check_outputs(string tag);
        chk({"R3 line ", tag}, hline_o, e_line);
        chk({"R4 sync-active ", tag}, hsa_o, e_sa);
        chk({"R5 hback ", tag}, hbp_o, e_bp);
        chk({"R6 vact ", tag}, vact_o, va);
        chk({"R6 vsync ", tag}, vsync_o, vsw);
        chk({"R6 vfront ", tag}, vfront_o, vso);
        chk({"R7 vback ", tag}, vback_o, e_vbp);
        chk({"R8 err ", tag}, err_o, e_err);
        chk({"R2 busy low at done ", tag}, busy_o, 0);
    endtask

    task automatic run_job(string tag);
        compute_exp();
        pulse_start();
        wait_done();
        check_outputs(tag);
        @(negedge clk);
        chk("R2 done single cycle", done_o, 0);
    endtask

    initial begin
        while (cycles < 190000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        ha = 0; hbl = 0; hso = 0; hsw = 0; va = 0; vbl = 0; vso = 0; vsw = 0;
        pclk = 0; bps = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy_o, 0);
        chk("R11 done", done_o, 0);
        chk("R11 err", err_o, 0);
        chk("R11 line", hline_o, 0);
        chk("R11 hbp", hbp_o, 0);
        chk("R11 vback", vback_o, 0);

        // sweep: R3 R4 R5 R6 R7 R8
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int s = 0; s < 3; s++)
                    for (int p = 0; p < 3; p++)
                        for (int r = 0; r < 2; r++) begin
                            ha   = (a == 0) ? 16'd1 : (a == 1) ? 16'd800 : 16'd65535;
                            hbl  = (b == 0) ? 16'd0 : (b == 1) ? 16'd40 : 16'd160;
                            hso  = (s == 0) ? 16'd0 : (s == 1) ? 16'd10 : 16'd50;
                            hsw  = (s == 0) ? 16'd0 : (s == 1) ? 16'd20 : 16'd120;
                            pclk = (p == 0) ? 20'd1 : (p == 1) ? 20'd27000 : 20'd148500;
                            bps  = (r == 0) ? 32'd480000000 : 32'd1500000000;
                            va   = ha;
                            vbl  = (r == 0) ? hbl : 16'(hbl / 4);
                            vso  = 16'(hso / 2);
                            vsw  = 16'(hsw / 4);
                            run_job("sweep");
                        end

        // R9 zero pixel clock
        ha = 1920; hbl = 280; hso = 88; hsw = 44; va = 1080; vbl = 45; vso = 4; vsw = 5;
        pclk = 0; bps = 891000000;
        run_job("R9 zero pclk");
        chk("R9 err flag", err_o, 1);
        chk("R9 line zero", hline_o, 0);

        // R1: start and new inputs while busy are ignored
        pclk = 148500;
        compute_exp();
        pulse_start();
        repeat (30) @(negedge clk);
        ha = 100; hbl = 0; hso = 5; hsw = 5; vbl = 0; pclk = 1; bps = 1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        va = 1080; vso = 4; vsw = 5;
        wait_done();
        chk("R1 ignored start line", hline_o, e_line);
        chk("R1 ignored start hbp", hbp_o, e_bp);
        chk("R1 ignored start err", err_o, e_err);
        @(negedge clk);
        @(negedge clk);
        chk("R1 no queued job", busy_o, 0);

        // R10 outputs hold while inputs change without start
        ha = 7; hbl = 9; pclk = 3; bps = 12345;
        repeat (10) @(negedge clk);
        chk("R10 hold line", hline_o, e_line);
        chk("R10 hold sync-active", hsa_o, e_sa);
        chk("R10 hold vback", vback_o, e_vbp);
        chk("R10 no done", done_o, 0);

        finish_run();
    end

endmodule